// File: doc/BRIEF.md
# Prescaled Eight-Bit Up-Timer with Overflow Flag

This block is an eight-bit up-counter advanced by a tick from a power-of-two prescaler on the system clock. Software-facing logic elsewhere drives it with single-cycle command strobes. One strobe loads a full eight-bit value. Two others overwrite either half of the count from a four-bit bus. The remaining strobes start and stop counting. The current count is read back one four-bit half at a time through a select input.

When the count rolls over from its top value to zero, a sticky timer flag is set and a one-cycle interrupt request pulse is produced. The flag is cleared in two ways: by an interrupt acknowledge, or by the strobe that accompanies a branch-on-timer test. The prescale exponent is fixed at elaboration. It may be any value from 0 to 13 except 6, and an illegal value stops elaboration.

Top module: `prescaled_timer`

## Requirements
- R1: While running, with no load or nibble write, the count rises by exactly one every 2^PRESCALE_EXP clock cycles. A start strobe clears the prescaler, so the first increment lands on the 2^PRESCALE_EXP-th rising edge after the edge that took the start.
- R2: From 8'hFF the count wraps to 8'h00 and keeps counting.
- R3: The edge that wraps the count sets `tmr_flag`. On that same edge `irq_req` goes high for exactly one cycle.
- R4: `ovf_test` or `irq_ack` clears `tmr_flag` on the next edge. If a wrap happens on that same edge, the flag stays set.
- R5: While `rst` is high on an edge, the timer stops, the count becomes 0, `tmr_flag` becomes 0 and `irq_req` becomes 0.
- R6: `ld_en` writes `ld_val` to the count on the next edge and stops the timer. Counting resumes only after a later `run_go` strobe.
- R7: `nib_wr_lo` replaces count bits 3:0 with `nib_in`, and `nib_wr_hi` replaces bits 7:4. The other half is kept and the run state is unchanged. A nibble write on a tick edge wins, and that increment is lost.
- R8: `nib_out` shows count bits 3:0 when `rd_hi` is 0 and bits 7:4 when `rd_hi` is 1. It follows the current count within the same cycle.
- R9: `run_halt` stops counting and the count then holds. If `run_halt` and `run_go` arrive together, the stop wins.
- R10: A PRESCALE_EXP of 6 or above 13 is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Load full count strobe (also stops) |
| ld_val | input | 8 | Value for a full load |
| nib_wr_lo | input | 1 | Write low half strobe |
| nib_wr_hi | input | 1 | Write high half strobe |
| nib_in | input | 4 | Data for half writes |
| run_go | input | 1 | Start counting strobe |
| run_halt | input | 1 | Stop counting strobe |
| rd_hi | input | 1 | Read select: 0 low half, 1 high half |
| nib_out | output | 4 | Selected half of the count |
| ovf_test | input | 1 | Flag test strobe, clears the flag |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| tmr_flag | output | 1 | Sticky overflow flag |
| irq_req | output | 1 | One-cycle overflow request pulse |

## Verification
A prescaler phase that drifts shows up as an increment one or more cycles early or late. `nib_out` exposes this on the first tick after a start, at most 2^PRESCALE_EXP cycles later. A wrong run state or a dropped write priority corrupts the count that the read mux shows on the very next cycle. A flag with the wrong clear or set priority differs at `tmr_flag` one edge after the conflicting strobe. The bench therefore compares both count halves and both flag outputs every cycle against its own model, and puts strobes directly on tick edges.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned NIB_W   = 4;
    localparam int unsigned NIB_CNT = 2;
    localparam int unsigned CNT_W   = NIB_W * NIB_CNT;
    localparam int unsigned EXP_MAX = 13;
    localparam int unsigned EXP_BAD = 6;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [NIB_W-1:0] nib_t;

    typedef struct packed {
        logic load;
        logic wr_lo;
        logic wr_hi;
        logic go;
        logic halt;
    } tmr_cmd_t;

    function automatic cnt_t nib_merge(input cnt_t cur, input nib_t nib,
                                       input logic lo, input logic hi);
        cnt_t r;
        r = cur;
        if (lo) r[NIB_W-1:0]     = nib;
        if (hi) r[CNT_W-1:NIB_W] = nib;
        return r;
    endfunction

    function automatic logic exp_legal(input int unsigned e);
        return (e <= EXP_MAX) && (e != EXP_BAD);
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int unsigned EXP = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic tick
);
    generate
        if (EXP == 0) begin : g_div1
            logic unused_pins;
            assign unused_pins = ^{clk, rst, restart};
            assign tick = run;
        end else begin : g_divn
            logic [EXP-1:0] phase;

            always_ff @(posedge clk) begin
                if (rst || restart || !run) phase <= '0;
                else                        phase <= phase + 1'b1;
            end

            assign tick = run && (phase == '1);

            // R1: a start clears the phase, so no tick directly after it
            a_r1_restart_quiet: assert property (@(posedge clk) disable iff (rst)
                restart |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  tmr_cmd_t cmd,
    input  cnt_t     load_val,
    input  nib_t     wr_nib,
    input  logic     tick,
    output cnt_t     cnt,
    output logic     running,
    output logic     ovf
);
    logic any_wr;
    assign any_wr = cmd.load | cmd.wr_lo | cmd.wr_hi;
    assign ovf    = tick && (cnt == '1) && !any_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            running <= 1'b0;
        end else begin
            if (cmd.load)                    cnt <= load_val;
            else if (cmd.wr_lo || cmd.wr_hi) cnt <= nib_merge(cnt, wr_nib, cmd.wr_lo, cmd.wr_hi);
            else if (tick)                   cnt <= cnt + 1'b1;

            if (cmd.load || cmd.halt) running <= 1'b0;
            else if (cmd.go)          running <= 1'b1;
        end
    end

    a_r2_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        ovf |=> (cnt == '0));

    a_r6_load_stops: assert property (@(posedge clk) disable iff (rst)
        cmd.load |=> (!running && cnt == $past(load_val)));

    a_r7_low_write_wins: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr_lo && !cmd.load) |=> (cnt[NIB_W-1:0] == $past(wr_nib)));

    a_r9_halt_wins: assert property (@(posedge clk) disable iff (rst)
        cmd.halt |=> !running);

    a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!running && !any_wr) |=> $stable(cnt));
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
    input  logic clk,
    input  logic rst,
    input  logic ovf,
    input  logic clr,
    output logic flag,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            irq  <= 1'b0;
        end else begin
            irq <= ovf;
            if (ovf)      flag <= 1'b1;
            else if (clr) flag <= 1'b0;
        end
    end

    a_r3_set_on_wrap: assert property (@(posedge clk) disable iff (rst)
        ovf |=> (flag && irq));

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    a_r4_clear: assert property (@(posedge clk) disable iff (rst)
        (clr && !ovf) |=> !flag);
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
    import tmr_pkg::*;
#(
    parameter int unsigned PRESCALE_EXP = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             nib_wr_lo,
    input  logic             nib_wr_hi,
    input  logic [NIB_W-1:0] nib_in,
    input  logic             run_go,
    input  logic             run_halt,
    input  logic             rd_hi,
    output logic [NIB_W-1:0] nib_out,
    input  logic             ovf_test,
    input  logic             irq_ack,
    output logic             tmr_flag,
    output logic             irq_req
);
    // R10: illegal exponents stop elaboration
    generate
        if (!exp_legal(PRESCALE_EXP)) begin : g_bad_exp
            $error("prescaled_timer: PRESCALE_EXP must be 0..13 and not 6");
        end
    endgenerate

    tmr_cmd_t cmd;
    cnt_t     count;
    logic     running;
    logic     tick;
    logic     ovf;

    assign cmd = '{load: ld_en, wr_lo: nib_wr_lo, wr_hi: nib_wr_hi,
                   go: run_go, halt: run_halt};

    tmr_prescale #(.EXP(PRESCALE_EXP)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (running),
        .restart (run_go),
        .tick    (tick)
    );

    tmr_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .load_val (ld_val),
        .wr_nib   (nib_in),
        .tick     (tick),
        .cnt      (count),
        .running  (running),
        .ovf      (ovf)
    );

    tmr_flag u_flag (
        .clk  (clk),
        .rst  (rst),
        .ovf  (ovf),
        .clr  (ovf_test | irq_ack),
        .flag (tmr_flag),
        .irq  (irq_req)
    );

    assign nib_out = rd_hi ? count[CNT_W-1:NIB_W] : count[NIB_W-1:0];

    // R5: coming out of reset everything is quiet
    a_r5_reset_quiet: assert property (@(posedge clk)
        rst |=> (!tmr_flag && !irq_req && nib_out == '0));
endmodule

// File: tb/test_prescaled_timer.sv
`timescale 1ns/1ps
module test_prescaled_timer;
    localparam int unsigned PEXP = 3;
    localparam int unsigned PDIV = 1 << PEXP;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ld_en = 0, nib_wr_lo = 0, nib_wr_hi = 0, run_go = 0, run_halt = 0;
    logic rd_hi = 0, ovf_test = 0, irq_ack = 0;
    logic [7:0] ld_val = 0;
    logic [3:0] nib_in = 0;
    logic [3:0] nib_out;
    logic tmr_flag, irq_req;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // reference state
    logic [7:0] m_cnt;
    logic m_run, m_flag, m_irq;
    int unsigned m_pre;

    always #2.5 clk = ~clk;

    prescaled_timer #(.PRESCALE_EXP(PEXP)) i_prescaled_timer (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_val(ld_val),
        .nib_wr_lo(nib_wr_lo), .nib_wr_hi(nib_wr_hi), .nib_in(nib_in),
        .run_go(run_go), .run_halt(run_halt), .rd_hi(rd_hi), .nib_out(nib_out),
        .ovf_test(ovf_test), .irq_ack(irq_ack), .tmr_flag(tmr_flag), .irq_req(irq_req)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic read_cnt(output logic [7:0] v);
        rd_hi = 1'b0; #0.5; v[3:0] = nib_out;
        rd_hi = 1'b1; #0.5; v[7:4] = nib_out;
    endtask

    function automatic logic [7:0] merge(input logic [7:0] c, input logic [3:0] n,
                                         input logic lo, input logic hi);
        logic [7:0] r = c;
        if (lo) r[3:0] = n;
        if (hi) r[7:4] = n;
        return r;
    endfunction

    // one clock: compare with model, drive strobes, advance model
    task automatic cycle(input logic ld, input logic [7:0] ldv, input logic wl,
                         input logic wh, input logic [3:0] wn, input logic st,
                         input logic sp, input logic ft, input logic ack);
        logic [7:0] seen;
        logic tk, ov, wr;
        read_cnt(seen);
        chk("R8 count readback", seen, m_cnt);
        chk("R3 flag", {7'd0, tmr_flag}, {7'd0, m_flag});
        chk("R3 irq", {7'd0, irq_req}, {7'd0, m_irq});
        ld_en = ld; ld_val = ldv; nib_wr_lo = wl; nib_wr_hi = wh; nib_in = wn;
        run_go = st; run_halt = sp; ovf_test = ft; irq_ack = ack;
        @(posedge clk);
        tk = m_run && (m_pre == PDIV - 1);
        wr = ld | wl | wh;
        ov = tk && (m_cnt == 8'hFF) && !wr;
        m_pre = (st || !m_run) ? 0 : ((m_pre + 1) % PDIV);
        if (ld) m_cnt = ldv;
        else if (wl || wh) m_cnt = merge(m_cnt, wn, wl, wh);
        else if (tk) m_cnt = m_cnt + 8'd1;
        if (ld || sp) m_run = 1'b0;
        else if (st) m_run = 1'b1;
        m_irq = ov;
        if (ov) m_flag = 1'b1;
        else if (ft || ack) m_flag = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic expect_cnt(input string tag, input logic [7:0] exp);
        logic [7:0] v;
        read_cnt(v);
        chk(tag, v, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        m_cnt = 0; m_run = 0; m_flag = 0; m_irq = 0; m_pre = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R5 reset state
        expect_cnt("R5 count after reset", 8'h00);
        chk("R5 flag after reset", {7'd0, tmr_flag}, 8'd0);
        chk("R5 irq after reset", {7'd0, irq_req}, 8'd0);

        // R6 load, no counting until start
        cycle(1, 8'hFE, 0, 0, 0, 0, 0, 0, 0);
        idle(10);
        expect_cnt("R6 held after load", 8'hFE);
        cycle(0, 0, 0, 0, 0, 1, 0, 0, 0);
        idle(PDIV - 1);
        expect_cnt("R1 no tick before period", 8'hFE);
        idle(1);
        expect_cnt("R1 tick at full period", 8'hFF);
        idle(PDIV);
        expect_cnt("R2 wrap to zero", 8'h00);
        chk("R3 flag on wrap", {7'd0, tmr_flag}, 8'd1);
        chk("R3 irq on wrap", {7'd0, irq_req}, 8'd1);
        idle(1);
        chk("R3 irq one cycle", {7'd0, irq_req}, 8'd0);
        chk("R3 flag sticky", {7'd0, tmr_flag}, 8'd1);
        cycle(0, 0, 0, 0, 0, 0, 0, 1, 0);
        chk("R4 test clears flag", {7'd0, tmr_flag}, 8'd0);

        // R4 set wins over a same-edge clear
        cycle(1, 8'hFF, 0, 0, 0, 0, 0, 0, 0);
        cycle(0, 0, 0, 0, 0, 1, 0, 0, 0);
        idle(PDIV - 1);
        cycle(0, 0, 0, 0, 0, 0, 0, 1, 0);
        chk("R4 set beats clear", {7'd0, tmr_flag}, 8'd1);
        expect_cnt("R2 wrap again", 8'h00);
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 1);
        chk("R4 ack clears flag", {7'd0, tmr_flag}, 8'd0);

        // R7 write beats tick
        cycle(1, 8'h10, 0, 0, 0, 0, 0, 0, 0);
        cycle(0, 0, 0, 0, 0, 1, 0, 0, 0);
        idle(PDIV - 1);
        cycle(0, 0, 1, 0, 4'h5, 0, 0, 0, 0);
        expect_cnt("R7 write drops tick", 8'h15);
        idle(PDIV);
        expect_cnt("R7 counting continues", 8'h16);
        cycle(0, 0, 0, 1, 4'hC, 0, 0, 0, 0);
        expect_cnt("R7 high half write", 8'hC6);
        idle(PDIV - 1);
        expect_cnt("R7 run state kept", 8'hC7);

        // R9 stop holds, stop beats start
        cycle(0, 0, 0, 0, 0, 0, 1, 0, 0);
        idle(20);
        expect_cnt("R9 held after stop", 8'hC7);
        cycle(0, 0, 0, 0, 0, 1, 1, 0, 0);
        idle(20);
        expect_cnt("R9 stop beats start", 8'hC7);

        // R8 half reads
        cycle(1, 8'hA5, 0, 0, 0, 0, 0, 0, 0);
        rd_hi = 1'b0; #0.5;
        chk("R8 low half", {4'd0, nib_out}, 8'h05);
        rd_hi = 1'b1; #0.5;
        chk("R8 high half", {4'd0, nib_out}, 8'h0A);
        @(negedge clk);

        // random mix, model compared every cycle
        for (int i = 0; i < 6000; i++) begin
            logic ld, wl, wh, st, sp, ft, ack;
            logic [7:0] v;
            ld  = ($urandom_range(99) < 2);
            wl  = ($urandom_range(99) < 3);
            wh  = ($urandom_range(99) < 2);
            st  = ($urandom_range(99) < 4);
            sp  = ($urandom_range(99) < 1);
            ft  = ($urandom_range(99) < 4);
            ack = ($urandom_range(99) < 4);
            v   = ($urandom_range(3) == 0) ? 8'($urandom) : 8'($urandom_range(255, 240));
            cycle(ld, v, wl, wh, 4'($urandom), st, sp, ft, ack);
        end
        idle(2);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule